// File: doc/BRIEF.md
# Memory Error First/Next Logger

This block sits beside an ECC datapath and records the memory error events it reports, so that software can find out what went wrong and where. Each event carries a 5-bit class code, the channel that saw it, and the location (bank, rank, column and row address) plus the syndrome and ECC locator of the failing word. The block keeps two summary views. The first-error word holds the earliest unmasked class together with its channel. The next-error word gathers every class that arrives while the first-error word is occupied.

Alongside the summaries, three detail slots keep location data. An uncorrectable slot and a correctable slot each hold class code, bank, rank, column and row. A data slot holds the syndrome and locator of a correctable error. Each slot has its own validity marker. A slot is frozen while its marker is set, so the oldest event of that kind stays readable until software acknowledges it. Software reads and writes everything through a flat register port. Status words and markers are cleared by writing ones. A mask word suppresses chosen classes, and it comes out of reset with every class suppressed.

Top module: `mem_err_logger`

## Requirements
- R1: After reset the first-error word (address 0), the next-error word (address 1) and the validity word (address 3) read 0. The mask word (address 2) reads 0x0001DC72, which has one bit set for each reportable class code 1, 4, 5, 6, 10, 11, 12, 14, 15 and 16. Unmapped addresses read 0.
- R2: An event with a reportable, unmasked code arrives while the first-error word has no class bit set. The first-error word then becomes bit `code` plus bit 28 equal to the event channel, and the next-error word does not change.
- R3: An event that arrives while the first-error word has a class bit set sets bit `code` in the next-error word, and the first-error word does not change.
- R4: An event whose code is not reportable, or whose mask bit is set, changes no status word, marker or log.
- R5: An uncorrectable event (codes 1, 4, 5, 6, 10, 11, 12) sets validity bit 0. If that bit was clear, it also loads uncorrectable log word A (address 4) and word B (address 5). Word A holds the code in bits 19:15, the bank in bits 14:12 and the rank in bits 10:8. Word B holds CAS in bits 28:16 and RAS in bits 15:0.
- R6: A correctable event (codes 14, 15, 16) sets validity bits 1 and 2. If bit 1 was clear, it loads correctable log words A and B (addresses 6 and 7) in the R5 layout. If bit 2 was clear, it loads the 32-bit syndrome (address 8) and the 18-bit locator in bits 17:0 (address 9).
- R7: A slot whose validity bit is set keeps its contents when later events of its kind arrive. Clearing one marker frees only that slot.
- R8: A write to address 0, 1 or 3 clears exactly the bits that are written as 1. A write to the mask word stores only the reportable class bits. Writes to log addresses have no effect.
- R9: When an event sets a status bit or marker in the same cycle that software clears it, the bit ends up set.
- R10: Once the first-error word has been cleared, the next reportable event is captured in it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_valid | input | 1 | Error event strobe, one cycle per event |
| ev_code | input | 5 | Error class code |
| ev_chan | input | 1 | Channel that raised the event |
| ev_bank | input | 3 | Bank of the failing access |
| ev_rank | input | 3 | Rank of the failing access |
| ev_cas | input | 13 | Column address |
| ev_ras | input | 16 | Row address |
| ev_syn | input | 32 | ECC syndrome |
| ev_loc | input | 18 | ECC locator |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 4 | Register address |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data, combinational from csr_addr |

## Verification
The assertions assume that the event inputs and register port carry known values whenever reset is inactive. They also assume that an event lasts one cycle and that at most one event arrives per cycle. The bench drives every input on the falling clock edge. It raises `ev_valid` for exactly one cycle per event and keeps all other inputs at defined values between events. Collisions between an event and a clear are produced on purpose by driving both in the same cycle.

// File: rtl/mel_pkg.sv
package mel_pkg;
  localparam int WORD_W   = 32;
  localparam int CODE_W   = 5;
  localparam int BANK_W   = 3;
  localparam int RANK_W   = 3;
  localparam int CAS_W    = 13;
  localparam int RAS_W    = 16;
  localparam int SYN_W    = 32;
  localparam int LOC_W    = 18;
  localparam int ADDR_W   = 4;
  localparam int CHAN_BIT = 28;

  localparam int CODE_LSB = 15;
  localparam int BANK_LSB = 12;
  localparam int RANK_LSB = 8;
  localparam int CAS_LSB  = 16;

  localparam logic [WORD_W-1:0] UNC_SET    = 32'h0000_1C72;
  localparam logic [WORD_W-1:0] COR_SET    = 32'h0001_C000;
  localparam logic [WORD_W-1:0] REPORT_SET = UNC_SET | COR_SET;
  localparam logic [WORD_W-1:0] FIRST_KEEP = REPORT_SET | (32'd1 << CHAN_BIT);

  localparam int MK_UNC = 0;
  localparam int MK_COR = 1;
  localparam int MK_DAT = 2;
  localparam int MK_N   = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_FIRST = 4'd0,
    RA_NEXT  = 4'd1,
    RA_MASK  = 4'd2,
    RA_VALID = 4'd3,
    RA_ULOGA = 4'd4,
    RA_ULOGB = 4'd5,
    RA_CLOGA = 4'd6,
    RA_CLOGB = 4'd7,
    RA_SYN   = 4'd8,
    RA_LOC   = 4'd9
  } reg_addr_e;
endpackage

// File: rtl/elog_classify.sv
module elog_classify
  import mel_pkg::*;
(
  input  logic              ev_valid,
  input  logic [CODE_W-1:0] ev_code,
  input  logic [WORD_W-1:0] mask,
  output logic [WORD_W-1:0] hit_vec,
  output logic              hit_unc,
  output logic              hit_cor
);
  logic [WORD_W-1:0] code_dec;

  always_comb begin
    code_dec = '0;
    code_dec[ev_code] = 1'b1;
    hit_vec  = ev_valid ? (code_dec & REPORT_SET & ~mask) : '0;
    hit_unc  = |(hit_vec & UNC_SET);
    hit_cor  = |(hit_vec & COR_SET);
  end
endmodule

// File: rtl/elog_status.sv
module elog_status
  import mel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] hit_vec,
  input  logic              ev_chan,
  input  logic [WORD_W-1:0] clr_first,
  input  logic [WORD_W-1:0] clr_next,
  output logic [WORD_W-1:0] first_q,
  output logic [WORD_W-1:0] next_q
);
  logic              first_any;
  logic              any_hit;
  logic [WORD_W-1:0] first_d;
  logic [WORD_W-1:0] next_d;
  logic [WORD_W-1:0] chan_word;

  always_comb begin
    first_any = |(first_q & REPORT_SET);
    any_hit   = |hit_vec;
    chan_word = '0;
    chan_word[CHAN_BIT] = ev_chan;
    first_d = first_q & ~clr_first;
    next_d  = next_q & ~clr_next;
    if (any_hit && !first_any) begin
      first_d = (hit_vec | chan_word) & FIRST_KEEP;
    end
    if (any_hit && first_any) begin
      next_d = next_d | hit_vec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      next_q  <= '0;
    end else begin
      first_q <= first_d;
      next_q  <= next_d;
    end
  end

  AST_FIRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (first_any && (clr_first == '0)) |=> $stable(first_q)); // R3

  AST_FIRST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ((|hit_vec) && !first_any) |=> ((first_q & $past(hit_vec)) != '0)); // R2

  AST_NEXT_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ((|hit_vec) && first_any) |=> ((next_q & $past(hit_vec)) == $past(hit_vec))); // R9

  AST_FIRST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(first_q & REPORT_SET) <= 1); // R2
endmodule

// File: rtl/elog_slot.sv
module elog_slot #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev,
  input  logic         clr,
  input  logic [W-1:0] din,
  output logic         mark_q,
  output logic [W-1:0] data_q
);
  logic cap;
  logic mark_d;

  always_comb begin
    cap    = ev && !mark_q;
    mark_d = (mark_q && !clr) || ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark_q <= 1'b0;
      data_q <= '0;
    end else begin
      mark_q <= mark_d;
      if (cap) begin
        data_q <= din;
      end
    end
  end

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_q && !clr) |=> $stable(data_q)); // R7

  AST_SLOT_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ev |=> mark_q); // R9

  AST_SLOT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && !mark_q) |=> (data_q == $past(din))); // R5
endmodule

// File: rtl/elog_detail.sv
module elog_detail
  import mel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_unc,
  input  logic              hit_cor,
  input  logic [CODE_W-1:0] ev_code,
  input  logic [BANK_W-1:0] ev_bank,
  input  logic [RANK_W-1:0] ev_rank,
  input  logic [CAS_W-1:0]  ev_cas,
  input  logic [RAS_W-1:0]  ev_ras,
  input  logic [SYN_W-1:0]  ev_syn,
  input  logic [LOC_W-1:0]  ev_loc,
  input  logic [MK_N-1:0]   clr_mark,
  output logic [MK_N-1:0]   mark_q,
  output logic [WORD_W-1:0] ulog_a,
  output logic [WORD_W-1:0] ulog_b,
  output logic [WORD_W-1:0] clog_a,
  output logic [WORD_W-1:0] clog_b,
  output logic [SYN_W-1:0]  syn_q,
  output logic [LOC_W-1:0]  loc_q
);
  localparam int LOGW = 2 * WORD_W;
  localparam int DATW = SYN_W + LOC_W;

  logic [WORD_W-1:0] word_a;
  logic [WORD_W-1:0] word_b;
  logic [LOGW-1:0]   ulog_q;
  logic [LOGW-1:0]   clog_q;
  logic [DATW-1:0]   dat_q;

  always_comb begin
    word_a = '0;
    word_a[CODE_LSB +: CODE_W] = ev_code;
    word_a[BANK_LSB +: BANK_W] = ev_bank;
    word_a[RANK_LSB +: RANK_W] = ev_rank;
    word_b = '0;
    word_b[CAS_LSB +: CAS_W] = ev_cas;
    word_b[0 +: RAS_W]       = ev_ras;
  end

  elog_slot #(.W(LOGW)) u_unc (
    .clk(clk), .rst_n(rst_n), .ev(hit_unc), .clr(clr_mark[MK_UNC]),
    .din({word_a, word_b}), .mark_q(mark_q[MK_UNC]), .data_q(ulog_q)
  );

  elog_slot #(.W(LOGW)) u_cor (
    .clk(clk), .rst_n(rst_n), .ev(hit_cor), .clr(clr_mark[MK_COR]),
    .din({word_a, word_b}), .mark_q(mark_q[MK_COR]), .data_q(clog_q)
  );

  elog_slot #(.W(DATW)) u_dat (
    .clk(clk), .rst_n(rst_n), .ev(hit_cor), .clr(clr_mark[MK_DAT]),
    .din({ev_syn, ev_loc}), .mark_q(mark_q[MK_DAT]), .data_q(dat_q)
  );

  assign ulog_a = ulog_q[LOGW-1:WORD_W];
  assign ulog_b = ulog_q[WORD_W-1:0];
  assign clog_a = clog_q[LOGW-1:WORD_W];
  assign clog_b = clog_q[WORD_W-1:0];
  assign syn_q  = dat_q[DATW-1:LOC_W];
  assign loc_q  = dat_q[LOC_W-1:0];
endmodule

// File: rtl/mem_err_logger.sv
module mem_err_logger
  import mel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [CODE_W-1:0] ev_code,
  input  logic              ev_chan,
  input  logic [BANK_W-1:0] ev_bank,
  input  logic [RANK_W-1:0] ev_rank,
  input  logic [CAS_W-1:0]  ev_cas,
  input  logic [RAS_W-1:0]  ev_ras,
  input  logic [SYN_W-1:0]  ev_syn,
  input  logic [LOC_W-1:0]  ev_loc,
  input  logic              csr_we,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [WORD_W-1:0] csr_wdata,
  output logic [WORD_W-1:0] csr_rdata
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [WORD_W-1:0] mask_q;
  logic [WORD_W-1:0] mask_d;
  logic              mask_en;
  logic [WORD_W-1:0] clr_first;
  logic [WORD_W-1:0] clr_next;
  logic [MK_N-1:0]   clr_mark;
  logic [WORD_W-1:0] hit_vec;
  logic              hit_unc;
  logic              hit_cor;
  logic [WORD_W-1:0] first_q;
  logic [WORD_W-1:0] next_q;
  logic [MK_N-1:0]   mark_q;
  logic [WORD_W-1:0] ulog_a;
  logic [WORD_W-1:0] ulog_b;
  logic [WORD_W-1:0] clog_a;
  logic [WORD_W-1:0] clog_b;
  logic [SYN_W-1:0]  syn_q;
  logic [LOC_W-1:0]  loc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    clr_first = (csr_we && (csr_addr == RA_FIRST)) ? csr_wdata : '0;
    clr_next  = (csr_we && (csr_addr == RA_NEXT))  ? csr_wdata : '0;
    clr_mark  = (csr_we && (csr_addr == RA_VALID)) ? csr_wdata[MK_N-1:0] : '0;
    mask_en   = csr_we && (csr_addr == RA_MASK);
    mask_d    = csr_wdata & REPORT_SET;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mask_q <= REPORT_SET;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  elog_classify u_classify (
    .ev_valid(ev_valid), .ev_code(ev_code), .mask(mask_q),
    .hit_vec(hit_vec), .hit_unc(hit_unc), .hit_cor(hit_cor)
  );

  elog_status u_status (
    .clk(clk), .rst_n(rst_int_n), .hit_vec(hit_vec), .ev_chan(ev_chan),
    .clr_first(clr_first), .clr_next(clr_next),
    .first_q(first_q), .next_q(next_q)
  );

  elog_detail u_detail (
    .clk(clk), .rst_n(rst_int_n), .hit_unc(hit_unc), .hit_cor(hit_cor),
    .ev_code(ev_code), .ev_bank(ev_bank), .ev_rank(ev_rank),
    .ev_cas(ev_cas), .ev_ras(ev_ras), .ev_syn(ev_syn), .ev_loc(ev_loc),
    .clr_mark(clr_mark), .mark_q(mark_q),
    .ulog_a(ulog_a), .ulog_b(ulog_b), .clog_a(clog_a), .clog_b(clog_b),
    .syn_q(syn_q), .loc_q(loc_q)
  );

  always_comb begin
    case (csr_addr)
      RA_FIRST: csr_rdata = first_q;
      RA_NEXT:  csr_rdata = next_q;
      RA_MASK:  csr_rdata = mask_q;
      RA_VALID: csr_rdata = {{(WORD_W-MK_N){1'b0}}, mark_q};
      RA_ULOGA: csr_rdata = ulog_a;
      RA_ULOGB: csr_rdata = ulog_b;
      RA_CLOGA: csr_rdata = clog_a;
      RA_CLOGB: csr_rdata = clog_b;
      RA_SYN:   csr_rdata = syn_q;
      RA_LOC:   csr_rdata = {{(WORD_W-LOC_W){1'b0}}, loc_q};
      default:  csr_rdata = '0;
    endcase
  end

  AST_MASK_LEGAL: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((mask_q & ~REPORT_SET) == '0)); // R8

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ev_valid && mask_q[ev_code] && (first_q != '0) && !csr_we) |=> $stable(next_q)); // R4
endmodule

// File: tb/mem_err_logger_bench.sv
module mem_err_logger_bench;
  logic        clk;
  logic        rst_n;
  logic        ev_valid;
  logic [4:0]  ev_code;
  logic        ev_chan;
  logic [2:0]  ev_bank;
  logic [2:0]  ev_rank;
  logic [12:0] ev_cas;
  logic [15:0] ev_ras;
  logic [31:0] ev_syn;
  logic [17:0] ev_loc;
  logic        csr_we;
  logic [3:0]  csr_addr;
  logic [31:0] csr_wdata;
  logic [31:0] csr_rdata;

  int n_checks = 0;
  int n_fails  = 0;

  mem_err_logger u_mem_err_logger (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_code(ev_code),
    .ev_chan(ev_chan), .ev_bank(ev_bank), .ev_rank(ev_rank), .ev_cas(ev_cas),
    .ev_ras(ev_ras), .ev_syn(ev_syn), .ev_loc(ev_loc), .csr_we(csr_we),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    csr_addr = a;
    #1;
    v = csr_rdata;
  endtask

  task automatic chk_reg(input string req, input string what,
                         input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, what, v, exp);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0; csr_wdata = '0;
  endtask

  task automatic drive_ev(input logic [4:0] code, input logic chan,
                          input logic [2:0] bank, input logic [2:0] rank,
                          input logic [12:0] cas, input logic [15:0] ras,
                          input logic [31:0] syn, input logic [17:0] loc);
    ev_valid = 1'b1; ev_code = code; ev_chan = chan; ev_bank = bank;
    ev_rank = rank; ev_cas = cas; ev_ras = ras; ev_syn = syn; ev_loc = loc;
  endtask

  task automatic send(input logic [4:0] code, input logic chan,
                      input logic [2:0] bank, input logic [2:0] rank,
                      input logic [12:0] cas, input logic [15:0] ras,
                      input logic [31:0] syn, input logic [17:0] loc);
    @(negedge clk);
    drive_ev(code, chan, bank, rank, cas, ras, syn, loc);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic send_code(input logic [4:0] code, input logic chan);
    send(code, chan, 3'd0, 3'd0, 13'd0, 16'd0, 32'd0, 18'd0);
  endtask

  task automatic clear_all();
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd1, 32'hFFFF_FFFF);
    wr(4'd3, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    chk_reg("R1", "first after reset", 4'd0, 32'h0);
    chk_reg("R1", "next after reset", 4'd1, 32'h0);
    chk_reg("R1", "mask after reset", 4'd2, 32'h0001_DC72);
    chk_reg("R1", "valid after reset", 4'd3, 32'h0);
    chk_reg("R1", "unmapped address", 4'd15, 32'h0);
  endtask

  task automatic t_first_capture();
    wr(4'd2, 32'h0);
    send_code(5'd14, 1'b1);
    chk_reg("R2", "first holds class 14 on channel 1", 4'd0, 32'h1000_4000);
    chk_reg("R2", "next untouched by first capture", 4'd1, 32'h0);
  endtask

  task automatic t_next_accum();
    send_code(5'd5, 1'b0);
    chk_reg("R3", "next gets class 5", 4'd1, 32'h0000_0020);
    send_code(5'd11, 1'b0);
    chk_reg("R3", "next accumulates class 11", 4'd1, 32'h0000_0820);
    chk_reg("R3", "first unchanged", 4'd0, 32'h1000_4000);
  endtask

  task automatic t_masked();
    clear_all();
    wr(4'd2, 32'h0000_0400);
    send_code(5'd10, 1'b1);
    chk_reg("R4", "masked class leaves first empty", 4'd0, 32'h0);
    chk_reg("R4", "masked class sets no marker", 4'd3, 32'h0);
    send_code(5'd2, 1'b0);
    chk_reg("R4", "non-reportable code leaves first empty", 4'd0, 32'h0);
    send_code(5'd31, 1'b0);
    chk_reg("R4", "code 31 leaves next empty", 4'd1, 32'h0);
    wr(4'd2, 32'h0);
  endtask

  task automatic t_uncorr_log();
    clear_all();
    send(5'd12, 1'b0, 3'd5, 3'd3, 13'h1ABC, 16'hBEEF, 32'h1111_2222, 18'h00123);
    chk_reg("R5", "valid after uncorrectable", 4'd3, 32'h1);
    chk_reg("R5", "uncorrectable word A", 4'd4, 32'h0006_5300);
    chk_reg("R5", "uncorrectable word B", 4'd5, 32'h1ABC_BEEF);
    chk_reg("R5", "syndrome not loaded by uncorrectable", 4'd8, 32'h0);
  endtask

  task automatic t_corr_log();
    send(5'd15, 1'b0, 3'd2, 3'd1, 13'h0123, 16'h4567, 32'hDEAD_BEEF, 18'h2ABCD);
    chk_reg("R6", "valid after correctable", 4'd3, 32'h7);
    chk_reg("R6", "correctable word A", 4'd6, 32'h0007_A100);
    chk_reg("R6", "correctable word B", 4'd7, 32'h0123_4567);
    chk_reg("R6", "syndrome", 4'd8, 32'hDEAD_BEEF);
    chk_reg("R6", "locator", 4'd9, 32'h0002_ABCD);
  endtask

  task automatic t_lock();
    send(5'd16, 1'b1, 3'd7, 3'd2, 13'h0FFF, 16'h0001, 32'h0BAD_F00D, 18'h00001);
    chk_reg("R7", "correctable word A kept", 4'd6, 32'h0007_A100);
    chk_reg("R7", "syndrome kept", 4'd8, 32'hDEAD_BEEF);
    send(5'd4, 1'b1, 3'd1, 3'd1, 13'h0001, 16'h0002, 32'h0, 18'h0);
    chk_reg("R7", "uncorrectable word A kept", 4'd4, 32'h0006_5300);
    wr(4'd3, 32'h0000_0002);
    chk_reg("R7", "only marker 1 cleared", 4'd3, 32'h5);
    send(5'd16, 1'b1, 3'd7, 3'd0, 13'h0000, 16'h0001, 32'h0BAD_F00D, 18'h00001);
    chk_reg("R7", "freed correctable slot reloaded", 4'd6, 32'h0008_7000);
    chk_reg("R7", "freed correctable word B", 4'd7, 32'h0000_0001);
    chk_reg("R7", "data slot still locked", 4'd8, 32'hDEAD_BEEF);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    clear_all();
    send_code(5'd1, 1'b0);
    send_code(5'd6, 1'b0);
    send_code(5'd16, 1'b0);
    rd(4'd1, v);
    chk("R8", "next before partial clear", v, 32'h0001_0040);
    wr(4'd1, 32'h0001_0000);
    chk_reg("R8", "only written one cleared", 4'd1, 32'h0000_0040);
    wr(4'd1, 32'h0);
    chk_reg("R8", "writing zeros clears nothing", 4'd1, 32'h0000_0040);
    wr(4'd4, 32'hFFFF_FFFF);
    chk_reg("R8", "log write ignored", 4'd4, 32'h0000_8000);
    wr(4'd2, 32'hFFFF_FFFF);
    chk_reg("R8", "mask keeps only class bits", 4'd2, 32'h0001_DC72);
    wr(4'd2, 32'h0);
    chk_reg("R8", "mask cleared", 4'd2, 32'h0);
  endtask

  task automatic t_collision();
    clear_all();
    send_code(5'd4, 1'b0);
    chk_reg("R9", "first holds class 4", 4'd0, 32'h0000_0010);
    send_code(5'd6, 1'b0);
    @(negedge clk);
    drive_ev(5'd6, 1'b0, 3'd0, 3'd0, 13'd0, 16'd0, 32'd0, 18'd0);
    csr_we = 1'b1; csr_addr = 4'd1; csr_wdata = 32'h0000_0040;
    @(negedge clk);
    ev_valid = 1'b0; csr_we = 1'b0; csr_wdata = '0;
    chk_reg("R9", "next bit survives simultaneous clear", 4'd1, 32'h0000_0040);
    send_code(5'd14, 1'b0);
    @(negedge clk);
    drive_ev(5'd15, 1'b0, 3'd3, 3'd3, 13'd3, 16'd3, 32'd3, 18'd3);
    csr_we = 1'b1; csr_addr = 4'd3; csr_wdata = 32'h0000_0006;
    @(negedge clk);
    ev_valid = 1'b0; csr_we = 1'b0; csr_wdata = '0;
    chk_reg("R9", "markers survive simultaneous clear", 4'd3, 32'h7);
  endtask

  task automatic t_recapture();
    wr(4'd0, 32'hFFFF_FFFF);
    chk_reg("R10", "first cleared", 4'd0, 32'h0);
    send_code(5'd1, 1'b0);
    chk_reg("R10", "first captures again", 4'd0, 32'h0000_0002);
  endtask

  initial begin
    rst_n = 1'b0; ev_valid = 1'b0; ev_code = '0; ev_chan = 1'b0;
    ev_bank = '0; ev_rank = '0; ev_cas = '0; ev_ras = '0; ev_syn = '0;
    ev_loc = '0; csr_we = 1'b0; csr_addr = '0; csr_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_first_capture();
    t_next_accum();
    t_masked();
    t_uncorr_log();
    t_corr_log();
    t_lock();
    t_w1c();
    t_collision();
    t_recapture();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule